// File: doc/BRIEF.md
# Registered Four-Bit ALU Datapath

This block is a small clocked arithmetic and logic stage. Two operand registers capture the incoming A and B words. A combinational function unit combines the two stored words, and its output is captured in a result register. Functions are chosen with a legacy control word. A mode bit picks logic or arithmetic. Four select lines, with the most significant line first, pick the function. An active-low carry input takes part in the arithmetic cases. Eight functions are defined, and every other control combination produces zero.

All three registers share one set of controls: a synchronous active-low clear, a synchronous active-low load and two active-high count enables. In normal use the load is held asserted, so the operands are taken on one rising edge and the result on the next. The mode, select and carry inputs are not registered. They steer the function unit directly and must hold their value up to the edge that captures the result. When load is released and both enables are high, each register counts up by one, modulo 2^W. When load is released and either enable is low, each register holds its value.

Top module: `alu4_regpath`

## Requirements
- R1: With mode_logic=1 and carry_n=1, the captured result is A AND B for sel=4'b1011, A OR B for sel=4'b1110, NOT A for sel=4'b0000, NOT(A AND B) for sel=4'b0100, and NOT(A OR B) for sel=4'b0001. Bit 0 is the least significant bit of every bus, and sel[3] is the most significant select line.
- R2: With mode_logic=0, sel=4'b1001 and carry_n=1, the result is A plus B, modulo 16.
- R3: With mode_logic=0, sel=4'b0110 and carry_n=0, the result is A minus B in two's complement, modulo 16.
- R4: With mode_logic=0, sel=4'b1111 and carry_n=1, the result is A minus 1, modulo 16.
- R5: Every combination of mode_logic, sel and carry_n that is not listed in R1 to R4 produces a result of 0.
- R6: With load_n=0, operands applied before a rising edge are captured on that edge. The result computed from them appears on f_out after the following edge. The control inputs act without a register, so a change made between the two edges sets the function used on the second edge.
- R7: clear_n=0 sets both operand registers and f_out to zero on the next rising edge, whatever the values of load_n and the enables.
- R8: With clear_n=1, load_n=1, cnt_en0=1 and cnt_en1=1, every register increments by one, modulo 16, on each rising edge.
- R9: With clear_n=1 and load_n=1, if either count enable is 0, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous load, active low |
| cnt_en0 | input | 1 | Count enable, active high |
| cnt_en1 | input | 1 | Second count enable, active high |
| opa | input | W (4) | Operand A input |
| opb | input | W (4) | Operand B input |
| mode_logic | input | 1 | 1 selects logic functions, 0 selects arithmetic functions |
| sel | input | 4 | Function select, sel[3] is the most significant line |
| carry_n | input | 1 | Carry input, active low |
| f_out | output | W (4) | Result register output |

## Verification
A corrupted operand register cannot be seen directly. It shows up in the next result word, one edge after the fault. An operand that fails to clear, count or hold therefore shows up when a later load captures a result that depends on it. The tests are arranged so that the value of each function reveals the operand state. For example, NOT A after a clear yields all ones. A wrong decode of the function or the carry shows up on f_out exactly two edges after the operands are applied. A wrong latency shows up at the first of those edges, because the previous result is still present there.

// File: rtl/alu4_regpath.sv
module alu4_regpath #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         cnt_en0,
  input  logic         cnt_en1,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         mode_logic,
  input  logic [3:0]   sel,
  input  logic         carry_n,
  output logic [W-1:0] f_out
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] ra, rb, alu_f;
  logic         counting;

  assign counting = cnt_en0 && cnt_en1;

  always_comb begin
    alu_f = '0;
    if (mode_logic) begin
      if (carry_n) begin
        case (sel)
          4'b1011: alu_f = ra & rb;
          4'b1110: alu_f = ra | rb;
          4'b0000: alu_f = ~ra;
          4'b0100: alu_f = ~(ra & rb);
          4'b0001: alu_f = ~(ra | rb);
          default: alu_f = '0;
        endcase
      end
    end else begin
      case ({sel, carry_n})
        5'b1001_1: alu_f = ra + rb;
        5'b0110_0: alu_f = ra + ~rb + ONE;
        5'b1111_1: alu_f = ra + ONES;
        default:   alu_f = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      ra    <= '0;
      rb    <= '0;
      f_out <= '0;
    end else if (!load_n) begin
      ra    <= opa;
      rb    <= opb;
      f_out <= alu_f;
    end else if (counting) begin
      ra    <= ra + ONE;
      rb    <= rb + ONE;
      f_out <= f_out + ONE;
    end
  end

endmodule

// File: rtl/alu4_regpath_chk.sv
module alu4_regpath_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic         cnt_en0,
  input logic         cnt_en1,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         mode_logic,
  input logic [3:0]   sel,
  input logic         carry_n,
  input logic [W-1:0] f_out,
  input logic [W-1:0] ra,
  input logic [W-1:0] rb
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clear_n;

  logic ld;
  assign ld = clear_n && !load_n;

  p_and_r1: assert property (@(posedge clk) disable iff (!armed)
    ld && mode_logic && carry_n && sel == 4'b1011 |=> f_out == ($past(ra) & $past(rb)));

  p_add_r2: assert property (@(posedge clk) disable iff (!armed)
    ld && !mode_logic && carry_n && sel == 4'b1001 |=> f_out == W'($past(ra) + $past(rb)));

  p_sub_r3: assert property (@(posedge clk) disable iff (!armed)
    ld && !mode_logic && !carry_n && sel == 4'b0110 |=> f_out == W'($past(ra) - $past(rb)));

  p_dec_r4: assert property (@(posedge clk) disable iff (!armed)
    ld && !mode_logic && carry_n && sel == 4'b1111 |=> f_out == W'($past(ra) - W'(1)));

  p_undef_r5: assert property (@(posedge clk) disable iff (!armed)
    ld && mode_logic && !carry_n |=> f_out == '0);

  p_load_r6: assert property (@(posedge clk) disable iff (!armed)
    ld |=> ra == $past(opa) && rb == $past(opb));

  p_clear_r7: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> f_out == '0 && ra == '0 && rb == '0);

  p_count_r8: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && cnt_en0 && cnt_en1 |=> f_out == W'($past(f_out) + W'(1)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && !(cnt_en0 && cnt_en1) |=> $stable(f_out) && $stable(ra) && $stable(rb));

endmodule

bind alu4_regpath alu4_regpath_chk #(.W(W)) u_chk (
  .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en0(cnt_en0), .cnt_en1(cnt_en1),
  .opa(opa), .opb(opb), .mode_logic(mode_logic), .sel(sel), .carry_n(carry_n),
  .f_out(f_out), .ra(ra), .rb(rb)
);

// File: tb/alu4_regpath_bench.sv
module alu4_regpath_bench;
  logic       clk = 1'b0;
  logic       clear_n = 1'b0, load_n = 1'b0, cnt_en0 = 1'b0, cnt_en1 = 1'b0;
  logic [3:0] opa = '0, opb = '0, sel = '0, f_out;
  logic       mode_logic = 1'b0, carry_n = 1'b1;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  alu4_regpath u_alu4_regpath (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en0(cnt_en0), .cnt_en1(cnt_en1),
    .opa(opa), .opb(opb), .mode_logic(mode_logic), .sel(sel), .carry_n(carry_n),
    .f_out(f_out)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    n_chk++;
    if (f_out !== exp) begin
      n_fail++;
      $display("FAIL %s: f_out=%b expected %b", tag, f_out, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic op(input string tag, input logic [3:0] a, input logic [3:0] b,
                    input logic m, input logic [3:0] s, input logic cn, input logic [3:0] exp);
    @(negedge clk);
    clear_n = 1'b1; load_n = 1'b0; opa = a; opb = b;
    mode_logic = m; sel = s; carry_n = cn;
    edges(2);
    check(tag, exp);
  endtask

  task automatic t_reset;
    clear_n = 1'b0;
    edges(1);
    check("R7 reset", 4'h0);
  endtask

  task automatic t_logic;
    op("R1 and",  4'b0111, 4'b0010, 1, 4'b1011, 1, 4'b0010);
    op("R1 or",   4'b0111, 4'b0010, 1, 4'b1110, 1, 4'b0111);
    op("R1 nota", 4'b0111, 4'b0010, 1, 4'b0000, 1, 4'b1000);
    op("R1 nand", 4'b0111, 4'b0010, 1, 4'b0100, 1, 4'b1101);
    op("R1 nor",  4'b0111, 4'b0010, 1, 4'b0001, 1, 4'b1000);
    op("R1 lsb",  4'b0001, 4'b0011, 1, 4'b1011, 1, 4'b0001);
  endtask

  task automatic t_arith;
    op("R2 add",      4'd7, 4'd2, 0, 4'b1001, 1, 4'd9);
    op("R2 add wrap", 4'd9, 4'd9, 0, 4'b1001, 1, 4'd2);
    op("R3 sub",      4'd7, 4'd2, 0, 4'b0110, 0, 4'd5);
    op("R3 sub neg",  4'd2, 4'd7, 0, 4'b0110, 0, 4'hB);
    op("R4 dec",      4'd7, 4'd2, 0, 4'b1111, 1, 4'd6);
    op("R4 dec wrap", 4'd0, 4'd2, 0, 4'b1111, 1, 4'hF);
  endtask

  task automatic t_undef;
    op("R5 and cn0",  4'hF, 4'hF, 1, 4'b1011, 0, 4'h0);
    op("R5 add cn0",  4'd7, 4'd2, 0, 4'b1001, 0, 4'h0);
    op("R5 sub cn1",  4'd7, 4'd2, 0, 4'b0110, 1, 4'h0);
    op("R5 logic sF", 4'd7, 4'd2, 1, 4'b1111, 1, 4'h0);
  endtask

  task automatic t_latency;
    op("R6 prime", 4'd0, 4'd0, 1, 4'b0000, 1, 4'hF);
    @(negedge clk); opa = 4'd6; opb = 4'd3;
    edges(1);
    check("R6 first edge", 4'hF);
    edges(1);
    check("R6 second edge", 4'h9);
    @(negedge clk); sel = 4'b1110;
    edges(1);
    check("R6 control unregistered", 4'h7);
  endtask

  task automatic t_clear;
    op("R7 prime", 4'd5, 4'd6, 0, 4'b1001, 1, 4'd11);
    @(negedge clk); clear_n = 1'b0; load_n = 1'b0; cnt_en0 = 1'b1; cnt_en1 = 1'b1;
    edges(1);
    check("R7 clear over load", 4'h0);
    @(negedge clk); clear_n = 1'b1; cnt_en0 = 1'b0; cnt_en1 = 1'b0;
    opa = 4'd5; mode_logic = 1'b1; sel = 4'b0000; carry_n = 1'b1;
    edges(1);
    check("R7 operand cleared", 4'hF);
  endtask

  task automatic t_count_hold;
    op("R8 prime", 4'd3, 4'd5, 0, 4'b1001, 1, 4'd8);
    @(negedge clk); load_n = 1'b1; cnt_en0 = 1'b1; cnt_en1 = 1'b1;
    edges(1);
    check("R8 count 1", 4'd9);
    edges(1);
    check("R8 count 2", 4'd10);
    @(negedge clk); cnt_en0 = 1'b0;
    edges(2);
    check("R9 hold en0 low", 4'd10);
    @(negedge clk); cnt_en0 = 1'b1; cnt_en1 = 1'b0;
    edges(1);
    check("R9 hold en1 low", 4'd10);
    @(negedge clk); load_n = 1'b0; cnt_en1 = 1'b0; opa = 4'd0; opb = 4'd0;
    edges(1);
    check("R8 R9 operands 5+7", 4'd12);
    op("R8 wrap prime", 4'hF, 4'd0, 0, 4'b1001, 1, 4'hF);
    @(negedge clk); load_n = 1'b1; cnt_en0 = 1'b1; cnt_en1 = 1'b1;
    edges(1);
    check("R8 wrap", 4'h0);
    @(negedge clk); cnt_en0 = 1'b0; cnt_en1 = 1'b0;
  endtask

  initial begin
    t_reset;
    t_logic;
    t_arith;
    t_undef;
    t_latency;
    t_clear;
    t_count_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule